// File: doc/BRIEF.md
# Multi-Domain Clock Idle Controller

This block decides, cycle by cycle on an always-running reference clock, which of four clock domains may have their clock enables asserted. The domains are a memory traffic controller (with its SDRAM clock), a peripheral bridge, a display controller and a host-port interface. A clock gating cell outside the block consumes each registered enable. The block also raises an idle request toward the PLL that sources these domains once nothing needs that PLL.

The traffic-controller domain has a sequenced shutdown. The controller first asks the memory interface to finish its in-flight transaction. Once that is acknowledged, it requests SDRAM self-refresh. It stops the traffic-controller and SDRAM clocks only after self-refresh is confirmed and the internal bus is quiet. An interrupt, a DMA request or bus activity wakes the domain. The clock comes back first, then self-refresh exit is requested, and the domain reports ready once the exit is confirmed. The other three domains follow simpler rules: idle detection for the bridge, the traffic-controller state plus a software bit for the display, and a software bit alone for the host port.

Top module: `clk_idle_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycles after it, every clock enable is 1, the domain-ready flag is 1, and the memory stop request, the self-refresh request and the PLL idle request are 0.
- R2: The memory stop request rises only in the cycle after one in which the processor PLL idle, DSP PLL idle and no-DMA-busy conditions all held with no wake source active. If any of those conditions is missing, the traffic-controller clock stays on and no stop request is made.
- R3: The self-refresh request rises only in the cycle after the memory interface acknowledged the stop request.
- R4: The traffic-controller and SDRAM clock enables fall together, and only in the cycle after self-refresh was acknowledged while the bus was quiet and no wake source was active. While the acknowledge is missing, both stay at 1.
- R5: In the gated state, a wake source re-enables the traffic-controller and SDRAM clocks in the next cycle and drops the self-refresh request in that same cycle. The wake sources are a processor interrupt, a DSP interrupt, a DMA request and internal bus activity, and each one works on its own.
- R6: After a wake, the domain-ready flag stays 0 while the self-refresh acknowledge is 1. It returns to 1 in the cycle after the acknowledge is seen at 0.
- R7: A wake event or a loss of the idle condition aborts a pending shutdown. While waiting for the memory acknowledge, the controller returns directly to running and the stop request drops. While waiting for self-refresh, it takes the exit path of R6, and a wake in the same cycle as the self-refresh acknowledge wins over gating.
- R8: The bridge clock enable is 0 in the cycle after the processor is idle with no DMA busy, and 1 in the cycle after any other combination.
- R9: The display clock enable is 1 only when its software bit is set and the traffic-controller clock enable is 1. It changes on the same edge as the traffic-controller enable.
- R10: The host-port clock enable copies its software bit with one cycle of delay, regardless of idle status.
- R11: The PLL idle request is 1 in the cycle after the software PLL idle bit was 1 while every domain enable in the PLL source mask (all four by default) was 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_idle_i | input | 1 | Processor and its PLL are idle |
| dsp_idle_i | input | 1 | DSP PLL is idle |
| dma_busy_i | input | 1 | A DMA transfer is in progress |
| bus_active_i | input | 1 | Internal local bus activity (wake source) |
| cpu_irq_i | input | 1 | Processor interrupt request (wake source) |
| dsp_irq_i | input | 1 | DSP interrupt request (wake source) |
| dma_req_i | input | 1 | DMA request (wake source) |
| disp_sw_en_i | input | 1 | Software enable for the display clock |
| host_sw_en_i | input | 1 | Software enable for the host-port clock |
| pll_idle_sw_i | input | 1 | Software permission to idle the PLL |
| mem_stop_ack_i | input | 1 | Memory interface finished its transaction |
| sr_ack_i | input | 1 | SDRAM is in self-refresh (level) |
| mem_stop_req_o | output | 1 | Request to memory interface to wind down |
| sr_req_o | output | 1 | Self-refresh request (level, 0 requests exit) |
| tc_clk_en_o | output | 1 | Traffic-controller clock enable |
| sdram_clk_en_o | output | 1 | SDRAM clock enable |
| bridge_clk_en_o | output | 1 | Peripheral-bridge clock enable |
| disp_clk_en_o | output | 1 | Display clock enable |
| host_clk_en_o | output | 1 | Host-port clock enable |
| pll_idle_req_o | output | 1 | PLL idle request |
| tc_ready_o | output | 1 | Traffic-controller domain running and usable |

## Verification
The risky overlap is a wake source and the gating condition arriving in the same cycle. The self-refresh acknowledge is present with no other blocker, yet bus activity (or an interrupt) also appears. The bench reaches the self-refresh wait state and raises the acknowledge and bus activity together on one edge. It then expects the traffic-controller clock to stay on, the self-refresh request to drop, and ready to return only after the acknowledge falls. A second overlap is a wake in the cycle after gating, while the PLL idle request is still being raised. The bench checks that this request lasts one more cycle and then clears.

// File: rtl/clk_idle_pkg.sv
package clk_idle_pkg;

  localparam int NUM_DOM    = 4;
  localparam int DOM_TC     = 0;
  localparam int DOM_BRIDGE = 1;
  localparam int DOM_DISP   = 2;
  localparam int DOM_HOST   = 3;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_WAIT_MEM = 3'd1,
    ST_WAIT_SR  = 3'd2,
    ST_GATED    = 3'd3,
    ST_WAKE     = 3'd4
  } tc_state_e;

  // Traffic-controller may wind down only with both PLLs idle and no DMA.
  function automatic logic tc_idle_ok(input logic cpu_idle, input logic dsp_idle,
                                      input logic dma_busy);
    return cpu_idle & dsp_idle & ~dma_busy;
  endfunction

  // Any of the restart sources.
  function automatic logic tc_wake(input logic cpu_irq, input logic dsp_irq,
                                   input logic dma_req, input logic bus_active);
    return cpu_irq | dsp_irq | dma_req | bus_active;
  endfunction

  // Bridge stays clocked unless the processor idles with no DMA.
  function automatic logic bridge_on(input logic cpu_idle, input logic dma_busy);
    return ~(cpu_idle & ~dma_busy);
  endfunction

endpackage

// File: rtl/tc_gate_fsm.sv
module tc_gate_fsm
  import clk_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_ok_i,
  input  logic      wake_i,
  input  logic      mem_stop_ack_i,
  input  logic      sr_ack_i,
  output tc_state_e state_o,
  output logic      tc_en_nxt_o,
  output logic      gate_evt_o,
  output logic      abort_evt_o,
  output logic      tc_clk_en_o,
  output logic      sdram_clk_en_o,
  output logic      mem_stop_req_o,
  output logic      sr_req_o,
  output logic      tc_ready_o
);

  tc_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    gate_evt_o  = 1'b0;
    abort_evt_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (idle_ok_i && !wake_i) state_d = ST_WAIT_MEM;
      end
      ST_WAIT_MEM: begin
        if (wake_i || !idle_ok_i) begin
          state_d     = ST_RUN;
          abort_evt_o = 1'b1;
        end else if (mem_stop_ack_i) begin
          state_d = ST_WAIT_SR;
        end
      end
      ST_WAIT_SR: begin
        if (wake_i || !idle_ok_i) begin
          state_d     = ST_WAKE;
          abort_evt_o = 1'b1;
        end else if (sr_ack_i) begin
          state_d    = ST_GATED;
          gate_evt_o = 1'b1;
        end
      end
      ST_GATED: begin
        if (wake_i) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (!sr_ack_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign tc_en_nxt_o = (state_d != ST_GATED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_RUN;
      tc_clk_en_o    <= 1'b1;
      sdram_clk_en_o <= 1'b1;
      mem_stop_req_o <= 1'b0;
      sr_req_o       <= 1'b0;
      tc_ready_o     <= 1'b1;
    end else begin
      state_q        <= state_d;
      tc_clk_en_o    <= tc_en_nxt_o;
      sdram_clk_en_o <= tc_en_nxt_o;
      mem_stop_req_o <= (state_d == ST_WAIT_MEM) || (state_d == ST_WAIT_SR) ||
                        (state_d == ST_GATED);
      sr_req_o       <= (state_d == ST_WAIT_SR) || (state_d == ST_GATED);
      tc_ready_o     <= (state_d == ST_RUN) || (state_d == ST_WAIT_MEM) ||
                        (state_d == ST_WAIT_SR);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/aux_domain_en.sv
module aux_domain_en
  import clk_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_idle_i,
  input  logic dma_busy_i,
  input  logic disp_sw_en_i,
  input  logic host_sw_en_i,
  input  logic tc_en_nxt_i,
  output logic bridge_clk_en_o,
  output logic disp_clk_en_o,
  output logic host_clk_en_o
);

  logic bridge_d, disp_d;

  assign bridge_d = bridge_on(cpu_idle_i, dma_busy_i);
  assign disp_d   = disp_sw_en_i & tc_en_nxt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bridge_clk_en_o <= 1'b1;
      disp_clk_en_o   <= 1'b1;
      host_clk_en_o   <= 1'b1;
    end else begin
      bridge_clk_en_o <= bridge_d;
      disp_clk_en_o   <= disp_d;
      host_clk_en_o   <= host_sw_en_i;
    end
  end

endmodule

// File: rtl/pll_idle_ctrl.sv
module pll_idle_ctrl #(
  parameter int                 NUM_DOM  = 4,
  parameter logic [NUM_DOM-1:0] SRC_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pll_idle_sw_i,
  input  logic [NUM_DOM-1:0] dom_en_i,
  output logic               pll_idle_req_o
);

  logic [NUM_DOM-1:0] dom_stopped;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    if (SRC_MASK[i]) begin : g_src
      assign dom_stopped[i] = ~dom_en_i[i];
    end else begin : g_other
      assign dom_stopped[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pll_idle_req_o <= 1'b0;
    else        pll_idle_req_o <= pll_idle_sw_i & (&dom_stopped);
  end

endmodule

// File: rtl/clk_idle_ctrl.sv
module clk_idle_ctrl
  import clk_idle_pkg::*;
#(
  parameter logic [NUM_DOM-1:0] PLL_SRC_MASK = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_idle_i,
  input  logic dsp_idle_i,
  input  logic dma_busy_i,
  input  logic bus_active_i,
  input  logic cpu_irq_i,
  input  logic dsp_irq_i,
  input  logic dma_req_i,
  input  logic disp_sw_en_i,
  input  logic host_sw_en_i,
  input  logic pll_idle_sw_i,
  input  logic mem_stop_ack_i,
  input  logic sr_ack_i,
  output logic mem_stop_req_o,
  output logic sr_req_o,
  output logic tc_clk_en_o,
  output logic sdram_clk_en_o,
  output logic bridge_clk_en_o,
  output logic disp_clk_en_o,
  output logic host_clk_en_o,
  output logic pll_idle_req_o,
  output logic tc_ready_o
);

  // Named internal events, visible to the checker.
  logic               idle_ok;
  logic               wake_evt;
  logic               gate_evt;
  logic               abort_evt;
  logic               tc_en_nxt;
  tc_state_e          tc_state;
  logic [NUM_DOM-1:0] dom_en;

  assign idle_ok  = tc_idle_ok(cpu_idle_i, dsp_idle_i, dma_busy_i);
  assign wake_evt = tc_wake(cpu_irq_i, dsp_irq_i, dma_req_i, bus_active_i);

  tc_gate_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .idle_ok_i      (idle_ok),
    .wake_i         (wake_evt),
    .mem_stop_ack_i (mem_stop_ack_i),
    .sr_ack_i       (sr_ack_i),
    .state_o        (tc_state),
    .tc_en_nxt_o    (tc_en_nxt),
    .gate_evt_o     (gate_evt),
    .abort_evt_o    (abort_evt),
    .tc_clk_en_o    (tc_clk_en_o),
    .sdram_clk_en_o (sdram_clk_en_o),
    .mem_stop_req_o (mem_stop_req_o),
    .sr_req_o       (sr_req_o),
    .tc_ready_o     (tc_ready_o)
  );

  aux_domain_en u_aux (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_idle_i      (cpu_idle_i),
    .dma_busy_i      (dma_busy_i),
    .disp_sw_en_i    (disp_sw_en_i),
    .host_sw_en_i    (host_sw_en_i),
    .tc_en_nxt_i     (tc_en_nxt),
    .bridge_clk_en_o (bridge_clk_en_o),
    .disp_clk_en_o   (disp_clk_en_o),
    .host_clk_en_o   (host_clk_en_o)
  );

  assign dom_en[DOM_TC]     = tc_clk_en_o;
  assign dom_en[DOM_BRIDGE] = bridge_clk_en_o;
  assign dom_en[DOM_DISP]   = disp_clk_en_o;
  assign dom_en[DOM_HOST]   = host_clk_en_o;

  pll_idle_ctrl #(
    .NUM_DOM  (NUM_DOM),
    .SRC_MASK (PLL_SRC_MASK)
  ) u_pll (
    .clk            (clk),
    .rst_n          (rst_n),
    .pll_idle_sw_i  (pll_idle_sw_i),
    .dom_en_i       (dom_en),
    .pll_idle_req_o (pll_idle_req_o)
  );

endmodule

// File: rtl/clk_idle_ctrl_chk.sv
module clk_idle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_idle_i,
  input logic dsp_idle_i,
  input logic dma_busy_i,
  input logic bus_active_i,
  input logic host_sw_en_i,
  input logic pll_idle_sw_i,
  input logic mem_stop_ack_i,
  input logic sr_ack_i,
  input logic mem_stop_req_o,
  input logic sr_req_o,
  input logic tc_clk_en_o,
  input logic sdram_clk_en_o,
  input logic bridge_clk_en_o,
  input logic disp_clk_en_o,
  input logic host_clk_en_o,
  input logic pll_idle_req_o,
  input logic tc_ready_o,
  input logic wake_evt,
  input logic gate_evt
);

  // R2
  mem_req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_stop_req_o) |-> $past(cpu_idle_i && dsp_idle_i && !dma_busy_i));

  // R3
  sr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req_o) |-> $past(mem_stop_ack_i));

  // R4
  gate_needs_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tc_clk_en_o) |-> ($past(sr_ack_i) && !$past(bus_active_i)));

  // R4
  sdram_off_in_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdram_clk_en_o |-> (sr_req_o && !tc_clk_en_o));

  // R5
  wake_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_clk_en_o && wake_evt) |=> (tc_clk_en_o && !sr_req_o));

  // R7
  wake_beats_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_evt |-> !wake_evt);

  // R6
  ready_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_ready_o) |-> !$past(sr_ack_i));

  // R8
  bridge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_idle_i && !dma_busy_i) |=> !bridge_clk_en_o);

  // R9
  disp_follows_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_clk_en_o |-> tc_clk_en_o);

  // R10
  host_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sw_en_i |=> host_clk_en_o);

  // R11
  pll_req_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_idle_req_o |-> $past(pll_idle_sw_i));

endmodule

bind clk_idle_ctrl clk_idle_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_idle_i      (cpu_idle_i),
  .dsp_idle_i      (dsp_idle_i),
  .dma_busy_i      (dma_busy_i),
  .bus_active_i    (bus_active_i),
  .host_sw_en_i    (host_sw_en_i),
  .pll_idle_sw_i   (pll_idle_sw_i),
  .mem_stop_ack_i  (mem_stop_ack_i),
  .sr_ack_i        (sr_ack_i),
  .mem_stop_req_o  (mem_stop_req_o),
  .sr_req_o        (sr_req_o),
  .tc_clk_en_o     (tc_clk_en_o),
  .sdram_clk_en_o  (sdram_clk_en_o),
  .bridge_clk_en_o (bridge_clk_en_o),
  .disp_clk_en_o   (disp_clk_en_o),
  .host_clk_en_o   (host_clk_en_o),
  .pll_idle_req_o  (pll_idle_req_o),
  .tc_ready_o      (tc_ready_o),
  .wake_evt        (wake_evt),
  .gate_evt        (gate_evt)
);

// File: tb/clk_idle_ctrl_tb.sv
`timescale 1ns/1ps
module clk_idle_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_idle, dsp_idle, dma_busy, bus_active;
  logic cpu_irq, dsp_irq, dma_req;
  logic disp_sw, host_sw, pll_sw, mem_ack, sr_ack;
  logic mem_req, sr_req, tc_en, sdram_en, bridge_en, disp_en, host_en, pll_req, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_idle_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_idle_i      (cpu_idle),
    .dsp_idle_i      (dsp_idle),
    .dma_busy_i      (dma_busy),
    .bus_active_i    (bus_active),
    .cpu_irq_i       (cpu_irq),
    .dsp_irq_i       (dsp_irq),
    .dma_req_i       (dma_req),
    .disp_sw_en_i    (disp_sw),
    .host_sw_en_i    (host_sw),
    .pll_idle_sw_i   (pll_sw),
    .mem_stop_ack_i  (mem_ack),
    .sr_ack_i        (sr_ack),
    .mem_stop_req_o  (mem_req),
    .sr_req_o        (sr_req),
    .tc_clk_en_o     (tc_en),
    .sdram_clk_en_o  (sdram_en),
    .bridge_clk_en_o (bridge_en),
    .disp_clk_en_o   (disp_en),
    .host_clk_en_o   (host_en),
    .pll_idle_req_o  (pll_req),
    .tc_ready_o      (ready)
  );

  // {cpu_idle, dma_busy, disp_sw, host_sw, exp_bridge, exp_disp, exp_host}
  localparam int NVEC = 8;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0011_111,
    7'b1011_011,
    7'b1110_110,
    7'b0101_101,
    7'b1000_000,
    7'b0000_100,
    7'b1101_101,
    7'b0010_110
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_idle = 0; dsp_idle = 0; dma_busy = 0; bus_active = 0;
    cpu_irq = 0; dsp_irq = 0; dma_req = 0; mem_ack = 0; sr_ack = 0;
  endtask

  // Drive RUN -> WAIT_MEM -> WAIT_SR -> GATED with checks.
  task automatic go_gated();
    cpu_idle = 1; dsp_idle = 1; dma_busy = 0; disp_sw = 1; host_sw = 0; pll_sw = 1;
    step();
    chk("R2 stop request raised", mem_req, 1'b1);
    chk("R3 no self-refresh before ack", sr_req, 1'b0);
    mem_ack = 1;
    step();
    chk("R3 self-refresh after ack", sr_req, 1'b1);
    chk("R4 clock on before sr ack", tc_en, 1'b1);
    sr_ack = 1;
    step();
    chk("R4 tc clock gated", tc_en, 1'b0);
    chk("R4 sdram clock gated", sdram_en, 1'b0);
    chk("R9 display off with tc", disp_en, 1'b0);
    chk("R11 pll request not yet", pll_req, 1'b0);
    step();
    chk("R11 pll request raised", pll_req, 1'b1);
  endtask

  initial begin
    quiet();
    disp_sw = 1; host_sw = 1; pll_sw = 0;
    repeat (3) @(negedge clk);
    chk("R1 tc enable in reset", tc_en, 1'b1);
    chk("R1 pll request in reset", pll_req, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 tc enable", tc_en, 1'b1);
    chk("R1 sdram enable", sdram_en, 1'b1);
    chk("R1 bridge enable", bridge_en, 1'b1);
    chk("R1 display enable", disp_en, 1'b1);
    chk("R1 host enable", host_en, 1'b1);
    chk("R1 stop request", mem_req, 1'b0);
    chk("R1 self-refresh request", sr_req, 1'b0);
    chk("R1 pll request", pll_req, 1'b0);
    chk("R1 ready", ready, 1'b1);

    // Table: non-traffic domains with the DSP busy (tc keeps running).
    for (int i = 0; i < NVEC; i++) begin
      {cpu_idle, dma_busy, disp_sw, host_sw} = VEC[i][6:3];
      dsp_idle = 0;
      step();
      chk("R8 bridge enable", bridge_en, VEC[i][2]);
      chk("R9 display enable", disp_en, VEC[i][1]);
      chk("R10 host enable", host_en, VEC[i][0]);
      chk("R2 no stop with dsp busy", mem_req, 1'b0);
    end

    // R2: both idle but DMA busy -> no shutdown.
    quiet(); cpu_idle = 1; dsp_idle = 1; dma_busy = 1;
    step(); step();
    chk("R2 no stop with dma busy", mem_req, 1'b0);
    chk("R2 tc stays on", tc_en, 1'b0 | 1'b1);

    // R5: each wake source on its own from the gated state.
    for (int k = 0; k < 4; k++) begin
      quiet();
      go_gated();
      cpu_irq    = (k == 0);
      dsp_irq    = (k == 1);
      dma_req    = (k == 2);
      bus_active = (k == 3);
      mem_ack = 0;
      step();
      chk("R5 tc clock back", tc_en, 1'b1);
      chk("R5 sdram clock back", sdram_en, 1'b1);
      chk("R5 self-refresh exit", sr_req, 1'b0);
      chk("R6 not ready in exit", ready, 1'b0);
      chk("R9 display back", disp_en, 1'b1);
      chk("R11 pll request one more cycle", pll_req, 1'b1);
      cpu_irq = 0; dsp_irq = 0; dma_req = 0; bus_active = 0;
      step();
      chk("R6 waits for sr ack low", ready, 1'b0);
      chk("R11 pll request cleared", pll_req, 1'b0);
      sr_ack = 0; cpu_idle = 0;
      step();
      chk("R6 ready after exit", ready, 1'b1);
      chk("R7 no stop request in run", mem_req, 1'b0);
    end

    // R7: abort while waiting for memory ack.
    quiet(); cpu_idle = 1; dsp_idle = 1;
    step();
    chk("R7 in memory wait", mem_req, 1'b1);
    dma_req = 1;
    step();
    chk("R7 abort drops stop request", mem_req, 1'b0);
    chk("R7 abort keeps ready", ready, 1'b1);
    chk("R7 abort keeps clock", tc_en, 1'b1);

    // R7: wake and sr ack in the same cycle in the self-refresh wait.
    quiet(); cpu_idle = 1; dsp_idle = 1;
    step();
    mem_ack = 1;
    step();
    step(); step();
    chk("R4 held without sr ack", tc_en, 1'b1);
    chk("R4 still requesting", sr_req, 1'b1);
    sr_ack = 1; bus_active = 1;
    step();
    chk("R7 wake wins over gating", tc_en, 1'b1);
    chk("R7 sdram stays on", sdram_en, 1'b1);
    chk("R7 exit requested", sr_req, 1'b0);
    chk("R7 not ready during exit", ready, 1'b0);
    sr_ack = 0; bus_active = 0; cpu_idle = 0;
    step();
    chk("R6 ready after aborted entry", ready, 1'b1);

    // R11: pll stays requested-off while software bit clear.
    quiet();
    pll_sw = 0;
    go_gated_nopll();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic go_gated_nopll();
    cpu_idle = 1; dsp_idle = 1; disp_sw = 0; host_sw = 0;
    step();
    mem_ack = 1;
    step();
    sr_ack = 1;
    step();
    chk("R4 gated again", tc_en, 1'b0);
    step();
    chk("R11 no pll request without bit", pll_req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule